// File: doc/BRIEF.md
# Banked Architectural Register Store

This block keeps the architectural state of a 16-bit processor core. It has eight primary 16-bit registers, a shadow bank of four registers, and a packed 15-bit flag word. The flag word holds the interrupt enables, the nesting enable, the priority level, the bank select and several mode bits. The core reads general registers through two independent combinational read ports. It writes them through one synchronous write port. The flag word has its own write input and its own read output.

Changing the bank-select bit of the flag word exchanges registers 1 to 4 with the shadow bank in a single clock edge. The block also exposes three derived views of the stored state: the 32-bit pair formed by registers 3 and 4, the data-segment field held in the status register, and the 22-bit program counter built from the status register and register 7.

After reset the block fetches a start address over a request/valid handshake and loads it into the program counter. It reports busy until that load happens. While busy, it ignores both write inputs.

Top module: `arch_regstore`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), all primary and shadow registers clear to 0. The flag word resets to 0x0808: the fetch-shift bit (bit 11) is 1, the level field (bits 3:0) is 8, and every other field is 0. `busy` and `vec_req` go high, and `vec_addr` is 0xFFF7.
- R2: After reset, `busy` and `vec_req` stay high until an edge samples `vec_valid` high. At that edge the program counter (index 7) takes `vec_data`, and `busy` and `vec_req` fall. After that, `vec_valid` has no effect on any register.
- R3: While `busy` is high, `wr_en` and `fr_wr_en` have no effect.
- R4: Index encoding: 0 stack pointer, 1 to 4 banked general registers, 5 base pointer, 6 status, 7 program counter. A write with `wr_en` high stores `wr_data` into register `wr_idx` at the clock edge.
- R5: `rd_a_data` and `rd_b_data` show the current contents of registers `rd_a_idx` and `rd_b_idx` combinationally, independently of each other.
- R6: The flag word layout is: bit 14 quotient, bit 13 bank select, bit 12 fraction mode, bit 11 fetch-shift, bits 10:7 shift extension, bit 6 fast-interrupt enable, bit 5 interrupt enable, bit 4 nesting enable, bits 3:0 level. A flag write with `fr_wr_en` high stores bits 14:0. `fr_rd_data` returns the stored bits in the same positions, with bit 15 always reading 0.
- R7: A flag write that changes bank select (bit 13) exchanges the contents of registers 1 to 4 with shadow registers 0 to 3 at the same edge.
- R8: A flag write that leaves bank select unchanged exchanges nothing, and the shadow registers keep their contents.
- R9: When a bank exchange and a register write occur in the same cycle, the exchange wins for indices 1 to 4 and the write to those indices is dropped. Writes to indices 0, 5, 6 and 7 still take effect. Reads in that cycle return the values from before the exchange.
- R10: `pair_data` equals {register 4, register 3}.
- R11: `data_seg` equals status bits 15:10. `pc_full` equals {status bits 5:0, register 7}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Register write index |
| wr_data | input | 16 | Register write data |
| fr_wr_en | input | 1 | Flag word write enable |
| fr_wr_data | input | 16 | Flag word write data (bit 15 ignored) |
| fr_rd_data | output | 16 | Flag word read data |
| pair_data | output | 32 | Register 4 : register 3 pair |
| data_seg | output | 6 | Data-segment field of status |
| pc_full | output | 22 | Extended program counter |
| vec_req | output | 1 | Start-address read request |
| vec_addr | output | 16 | Start-address read address |
| vec_valid | input | 1 | Start-address read data valid |
| vec_data | input | 16 | Start-address read data |
| busy | output | 1 | High until the program counter is loaded |

## Verification
The bench runs several directed patterns, each aimed at one behaviour:
- a held-off handshake with writes attempted during it, which separates a correct busy gate from a leaky one;
- a late `vec_valid` pulse, which shows whether the program counter keeps accepting data after the load;
- flag writes that toggle bank select and flag writes that rewrite it unchanged, which distinguish a bank exchange from a spurious one;
- same-cycle exchange and write, aimed both at a banked index and at an unbanked one, with pre-edge reads, which pins the priority and shows that reads see the pre-exchange values.

A long seeded random mix of writes, flag writes and read indices is then compared against a bench model. It catches index decoding, port crosstalk and derived-view errors that the directed cases miss.

// File: rtl/regstore_pkg.sv
// Shared widths, register indices and flag word layout for the register store.
// Assumes a 16-bit datapath and a 15-bit flag word stored below bit 15.
package regstore_pkg;
    localparam int unsigned WORD_W     = 16;
    localparam int unsigned NUM_PRIM   = 8;
    localparam int unsigned NUM_SHADOW = 4;
    localparam int unsigned BANK_LO    = 1;
    localparam int unsigned SEG_W      = 6;
    localparam int unsigned PCHI_W     = 6;
    localparam int unsigned IDX_W      = $clog2(NUM_PRIM);
    localparam int unsigned PC_IDX     = NUM_PRIM - 1;
    localparam int unsigned SR_IDX     = NUM_PRIM - 2;
    localparam int unsigned PAIR_LO    = 3;
    localparam int unsigned PAIR_HI    = 4;

    // Flag word fields, most significant first; bank_sel sits at bit 13
    typedef struct packed {
        logic       quot_bit;
        logic       bank_sel;
        logic       frac_mode;
        logic       fetch_shift;
        logic [3:0] shift_ext;
        logic       fast_irq_en;
        logic       irq_en;
        logic       nest_en;
        logic [3:0] level;
    } flags_t;

    localparam int unsigned FLAGS_W = $bits(flags_t);

    localparam flags_t FLAGS_RST = '{
        quot_bit: 1'b0, bank_sel: 1'b0, frac_mode: 1'b0, fetch_shift: 1'b1,
        shift_ext: 4'd0, fast_irq_en: 1'b0, irq_en: 1'b0, nest_en: 1'b0,
        level: 4'd8
    };
endpackage

// File: rtl/vec_fetch.sv
// Start-address fetch sequencer.
// After reset it raises a read request at a fixed address and holds it until
// valid data returns. It then pulses a load strobe and leaves the busy state for good.
// Assumes the memory side answers with vec_valid while the request is up.
module vec_fetch #(
    parameter int unsigned          AW       = 16,
    parameter int unsigned          DW       = 16,
    parameter logic [AW-1:0]        VEC_ADDR = 16'hFFF7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vec_valid,
    input  logic [DW-1:0] vec_data,
    output logic          vec_req,
    output logic [AW-1:0] vec_addr,
    output logic          busy,
    output logic          load_o,
    output logic [DW-1:0] load_val_o
);
    typedef enum logic {FETCHING = 1'b0, RUNNING = 1'b1} fstate_t;

    fstate_t state_q;

    // Advance from fetching to running once the vector word arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FETCHING;
        end else if (state_q == FETCHING && vec_valid) begin
            state_q <= RUNNING;
        end
    end

    // Request, busy and load strobe decoded from the state
    always_comb begin
        busy       = (state_q == FETCHING);
        vec_req    = busy;
        vec_addr   = VEC_ADDR;
        load_o     = busy && vec_valid;
        load_val_o = vec_data;
    end

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vec_valid) |=> busy);
    assert_busy_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vec_valid) |=> !busy);
    assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
endmodule

// File: rtl/flag_reg.sv
// Flag word register.
// It stores the 15 flag bits on a write and returns them with bit 15 as zero.
// It flags a bank exchange when a write changes the bank-select bit.
// Assumes the write enable is already gated by the caller.
module flag_reg
    import regstore_pkg::*;
#(
    parameter int unsigned FW = FLAGS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [FW-1:0] wdata,
    output logic [FW:0]   rdata,
    output logic          swap_o
);
    flags_t flags_q;
    flags_t flags_nxt;

    // Decode incoming word and detect a bank-select change
    always_comb begin
        flags_nxt = flags_t'(wdata);
        swap_o    = we && (flags_nxt.bank_sel != flags_q.bank_sel);
        rdata     = {1'b0, flags_q};
    end

    // Flag storage with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_RST;
        end else if (we) begin
            flags_q <= flags_nxt;
        end
    end

    assert_fr_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == {1'b0, $past(wdata)}));
    assert_swap_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> (flags_q.bank_sel != $past(flags_q.bank_sel)));
    assert_fr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flags_q));
endmodule

// File: rtl/gpr_bank.sv
// Primary register array with a shadow bank.
// It gives two combinational read ports and one write port. A swap strobe
// exchanges the banked range with the shadow registers, and the exchange
// overrides writes aimed at that range. A load strobe sets the program counter.
// Assumes load and write never coincide (the caller gates writes while loading).
module gpr_bank
    import regstore_pkg::*;
#(
    parameter int unsigned DW    = WORD_W,
    parameter int unsigned NPRIM = NUM_PRIM,
    parameter int unsigned NSHAD = NUM_SHADOW,
    parameter int unsigned BLO   = BANK_LO
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(NPRIM)-1:0]   rd_a_idx,
    input  logic [$clog2(NPRIM)-1:0]   rd_b_idx,
    output logic [DW-1:0]              rd_a_data,
    output logic [DW-1:0]              rd_b_data,
    input  logic                       we,
    input  logic [$clog2(NPRIM)-1:0]   widx,
    input  logic [DW-1:0]              wdata,
    input  logic                       swap_i,
    input  logic                       load_i,
    input  logic [DW-1:0]              load_val_i,
    output logic [NPRIM-1:0][DW-1:0]   regs_o
);
    localparam int unsigned IW    = $clog2(NPRIM);
    localparam int unsigned LAST  = NPRIM - 1;
    localparam int unsigned BHI   = BLO + NSHAD;

    logic [NPRIM-1:0][DW-1:0] prim_q;
    logic [NPRIM-1:0][DW-1:0] prim_nxt;
    logic [NSHAD-1:0][DW-1:0] shad_q;
    logic [NSHAD-1:0][DW-1:0] shad_nxt;
    logic [NPRIM-1:0]         wr_hit;

    // Next value per primary register: load, then exchange, then write
    for (genvar gi = 0; gi < NPRIM; gi++) begin : g_prim
        assign wr_hit[gi] = we && (widx == IW'(gi));
        if (gi == LAST) begin : g_pc
            assign prim_nxt[gi] = load_i     ? load_val_i :
                                  wr_hit[gi] ? wdata      : prim_q[gi];
        end else if (gi >= BLO && gi < BHI) begin : g_banked
            assign prim_nxt[gi] = swap_i     ? shad_q[gi-BLO] :
                                  wr_hit[gi] ? wdata          : prim_q[gi];
        end else begin : g_plain
            assign prim_nxt[gi] = wr_hit[gi] ? wdata : prim_q[gi];
        end
    end

    // Next value per shadow register: take the banked primary on exchange
    for (genvar gj = 0; gj < NSHAD; gj++) begin : g_shad
        assign shad_nxt[gj] = swap_i ? prim_q[gj+BLO] : shad_q[gj];
    end

    // Register storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q <= '0;
            shad_q <= '0;
        end else begin
            prim_q <= prim_nxt;
            shad_q <= shad_nxt;
        end
    end

    // Combinational read ports and full state view
    always_comb begin
        rd_a_data = prim_q[rd_a_idx];
        rd_b_data = prim_q[rd_b_idx];
        regs_o    = prim_q;
    end

    assert_swap_exchange_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (prim_q[BLO] == $past(shad_q[0]) && shad_q[0] == $past(prim_q[BLO])));
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(shad_q));
    assert_swap_beats_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && we && widx == IW'(BLO)) |=> (prim_q[BLO] == $past(shad_q[0])));
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !swap_i && !load_i) |=> (prim_q[$past(widx)] == $past(wdata)));
    assert_vec_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (prim_q[LAST] == $past(load_val_i)));
endmodule

// File: rtl/arch_regstore.sv
// Architectural register store top.
// It ties together the start-address fetch, the flag word and the banked register array.
// It gates both write inputs while the fetch is pending and derives the pair,
// data-segment and extended program counter views.
// Assumes a single clock and a synchronous active-low reset.
module arch_regstore
    import regstore_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          rd_a_idx,
    output logic [WORD_W-1:0]         rd_a_data,
    input  logic [IDX_W-1:0]          rd_b_idx,
    output logic [WORD_W-1:0]         rd_b_data,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic                      fr_wr_en,
    input  logic [WORD_W-1:0]         fr_wr_data,
    output logic [WORD_W-1:0]         fr_rd_data,
    output logic [2*WORD_W-1:0]       pair_data,
    output logic [SEG_W-1:0]          data_seg,
    output logic [PCHI_W+WORD_W-1:0]  pc_full,
    output logic                      vec_req,
    output logic [WORD_W-1:0]         vec_addr,
    input  logic                      vec_valid,
    input  logic [WORD_W-1:0]         vec_data,
    output logic                      busy
);
    logic                           wr_en_g;
    logic                           fr_we_g;
    logic                           swap;
    logic                           vec_load;
    logic [WORD_W-1:0]              vec_load_val;
    logic [NUM_PRIM-1:0][WORD_W-1:0] regs;
    logic [FLAGS_W:0]               fr_word;
    logic                           fr_msb_unused;

    // Block all writes until the start address is in place
    always_comb begin
        wr_en_g       = wr_en && !busy;
        fr_we_g       = fr_wr_en && !busy;
        fr_msb_unused = fr_wr_data[WORD_W-1];
    end

    vec_fetch #(.AW(WORD_W), .DW(WORD_W), .VEC_ADDR(16'hFFF7)) i_vec_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_valid  (vec_valid),
        .vec_data   (vec_data),
        .vec_req    (vec_req),
        .vec_addr   (vec_addr),
        .busy       (busy),
        .load_o     (vec_load),
        .load_val_o (vec_load_val)
    );

    flag_reg #(.FW(FLAGS_W)) i_flag_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (fr_we_g),
        .wdata  (fr_wr_data[FLAGS_W-1:0]),
        .rdata  (fr_word),
        .swap_o (swap)
    );

    gpr_bank #(.DW(WORD_W), .NPRIM(NUM_PRIM), .NSHAD(NUM_SHADOW), .BLO(BANK_LO)) i_gpr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (rd_a_idx),
        .rd_b_idx   (rd_b_idx),
        .rd_a_data  (rd_a_data),
        .rd_b_data  (rd_b_data),
        .we         (wr_en_g),
        .widx       (wr_idx),
        .wdata      (wr_data),
        .swap_i     (swap),
        .load_i     (vec_load),
        .load_val_i (vec_load_val),
        .regs_o     (regs)
    );

    // Derived views of the stored state
    always_comb begin
        fr_rd_data = fr_word;
        pair_data  = {regs[PAIR_HI], regs[PAIR_LO]};
        data_seg   = regs[SR_IDX][WORD_W-1 -: SEG_W];
        pc_full    = {regs[SR_IDX][PCHI_W-1:0], regs[PC_IDX]};
    end

    assert_busy_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vec_valid) |=> ($stable(fr_rd_data) && $stable(pair_data) && $stable(data_seg)));
    assert_fr_msb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fr_rd_data[WORD_W-1] == 1'b0);
endmodule

// File: tb/test_arch_regstore.sv
`timescale 1ns/1ps
module test_arch_regstore;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [15:0] rd_a_data, rd_b_data, wr_data, fr_wr_data, fr_rd_data;
    logic        wr_en, fr_wr_en, vec_req, vec_valid, busy;
    logic [31:0] pair_data;
    logic [5:0]  data_seg;
    logic [21:0] pc_full;
    logic [15:0] vec_addr, vec_data;

    always #4 clk = ~clk;

    arch_regstore i_arch_regstore (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .fr_wr_en(fr_wr_en), .fr_wr_data(fr_wr_data), .fr_rd_data(fr_rd_data),
        .pair_data(pair_data), .data_seg(data_seg), .pc_full(pc_full),
        .vec_req(vec_req), .vec_addr(vec_addr), .vec_valid(vec_valid),
        .vec_data(vec_data), .busy(busy)
    );

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] m_prim [8];
    logic [15:0] m_shad [4];
    logic [15:0] m_fr;
    logic        m_busy;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bench model of one clock edge, applied from the inputs present at that edge
    task automatic model_edge();
        logic chg;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_prim[i] = 16'h0;
            for (int i = 0; i < 4; i++) m_shad[i] = 16'h0;
            m_fr = 16'h0808;
            m_busy = 1'b1;
        end else if (m_busy) begin
            if (vec_valid) begin
                m_prim[7] = vec_data;
                m_busy = 1'b0;
            end
        end else begin
            chg = fr_wr_en && (fr_wr_data[13] != m_fr[13]);
            if (wr_en && !(chg && wr_idx >= 3'd1 && wr_idx <= 3'd4)) m_prim[wr_idx] = wr_data;
            if (fr_wr_en) m_fr = {1'b0, fr_wr_data[14:0]};
            if (chg) begin
                for (int i = 0; i < 4; i++) begin
                    logic [15:0] t;
                    t = m_prim[i+1];
                    m_prim[i+1] = m_shad[i];
                    m_shad[i] = t;
                end
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic drive(input logic we, input logic [2:0] idx, input logic [15:0] d,
                         input logic fe, input logic [15:0] fd);
        wr_en = we; wr_idx = idx; wr_data = d; fr_wr_en = fe; fr_wr_data = fd;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 16'h0, 1'b0, 16'h0);
    endtask

    task automatic check_views(input string req);
        chk(req, "fr_rd_data", {16'h0, fr_rd_data}, {16'h0, m_fr});
        chk("R10", "pair_data", pair_data, {m_prim[4], m_prim[3]});
        chk("R11", "data_seg", {26'h0, data_seg}, {26'h0, m_prim[6][15:10]});
        chk("R11", "pc_full", {10'h0, pc_full}, {10'h0, m_prim[6][5:0], m_prim[7]});
        chk(req, "busy", {31'h0, busy}, {31'h0, m_busy});
        chk(req, "vec_req", {31'h0, vec_req}, {31'h0, m_busy});
    endtask

    // Reads every register through both ports; inputs must be idle
    task automatic read_all(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_a_idx = 3'(i);
            rd_b_idx = 3'(7 - i);
            #0.5;
            chk(req, $sformatf("rd_a[%0d]", i), {16'h0, rd_a_data}, {16'h0, m_prim[i]});
            chk(req, $sformatf("rd_b[%0d]", 7 - i), {16'h0, rd_b_data}, {16'h0, m_prim[7 - i]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd7321));
        rst_n = 1'b0; vec_valid = 1'b0; vec_data = 16'h0;
        rd_a_idx = 3'd0; rd_b_idx = 3'd0;
        idle();
        @(negedge clk);
        repeat (3) tick();

        // R1: reset values
        read_all("R1");
        check_views("R1");
        chk("R1", "vec_addr", {16'h0, vec_addr}, 32'h0000FFF7);
        @(negedge clk);

        // R3: writes attempted while the fetch is pending
        rst_n = 1'b1;
        drive(1'b1, 3'd1, 16'hAAAA, 1'b1, 16'h2000);
        tick();
        drive(1'b1, 3'd7, 16'h5555, 1'b1, 16'h7FFF);
        tick();
        idle();
        tick();
        chk("R2", "busy held", {31'h0, busy}, 32'h1);
        read_all("R3");
        check_views("R3");
        @(negedge clk);

        // R2: vector word returns
        vec_valid = 1'b1; vec_data = 16'h1234;
        tick();
        vec_valid = 1'b0;
        chk("R2", "pc after load", {16'h0, m_prim[7]}, 32'h1234);
        read_all("R2");
        check_views("R2");
        @(negedge clk);
        vec_valid = 1'b1; vec_data = 16'hBEEF;
        tick();
        vec_valid = 1'b0;
        read_all("R2");
        chk("R2", "pc ignores late valid", {16'h0, rd_a_data}, {16'h0, 16'h1234});
        @(negedge clk);

        // R4: fill every index
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 3'(i), 16'(16'h1111 * (i + 1)), 1'b0, 16'h0);
            tick();
        end
        idle();
        read_all("R4");

        // R10, R11: pair and derived views
        @(negedge clk);
        drive(1'b1, 3'd3, 16'h5678, 1'b0, 16'h0); tick();
        drive(1'b1, 3'd4, 16'h9ABC, 1'b0, 16'h0); tick();
        drive(1'b1, 3'd6, 16'hFC2A, 1'b0, 16'h0); tick();
        idle();
        check_views("R11");
        chk("R10", "pair value", pair_data, 32'h9ABC5678);
        chk("R11", "seg value", {26'h0, data_seg}, 32'h3F);

        // R6, R7: all-ones flag write toggles the bank
        drive(1'b0, 3'd0, 16'h0, 1'b1, 16'hFFFF);
        tick();
        idle();
        chk("R6", "fr msb reads zero", {16'h0, fr_rd_data}, 32'h7FFF);
        read_all("R7");
        chk("R7", "r1 from shadow", {16'h0, m_prim[1]}, 32'h0);
        @(negedge clk);

        // R8: rewrite with bank unchanged
        drive(1'b0, 3'd0, 16'h0, 1'b1, 16'h2808);
        tick();
        idle();
        read_all("R8");
        check_views("R8");
        @(negedge clk);

        // R9: exchange plus write to a banked index, pre-edge read
        drive(1'b1, 3'd2, 16'hDEAD, 1'b1, 16'h0808);
        rd_a_idx = 3'd2;
        #1;
        chk("R9", "pre-swap read", {16'h0, rd_a_data}, {16'h0, m_prim[2]});
        tick();
        idle();
        read_all("R9");
        @(negedge clk);
        // R9: exchange plus write to an unbanked index
        drive(1'b1, 3'd5, 16'hC0DE, 1'b1, 16'h2808);
        tick();
        idle();
        read_all("R9");
        chk("R9", "unbanked write kept", {16'h0, m_prim[5]}, 32'hC0DE);
        @(negedge clk);

        // R5: random mix against the model
        for (int n = 0; n < 600; n++) begin
            drive(($urandom() % 3) != 0, 3'($urandom()), 16'($urandom()),
                  ($urandom() % 4) == 0, 16'($urandom()));
            rd_a_idx = 3'($urandom());
            rd_b_idx = 3'($urandom());
            #1;
            chk("R5", "rand rd_a", {16'h0, rd_a_data}, {16'h0, m_prim[rd_a_idx]});
            chk("R5", "rand rd_b", {16'h0, rd_b_data}, {16'h0, m_prim[rd_b_idx]});
            tick();
            check_views("R4");
        end
        idle();

        // R1: mid-run reset, then check shadow cleared via a bank toggle
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        read_all("R1");
        check_views("R1");
        @(negedge clk);
        vec_valid = 1'b1; vec_data = 16'h0400;
        tick();
        vec_valid = 1'b0;
        d = 16'h2808;
        drive(1'b0, 3'd0, 16'h0, 1'b1, d);
        tick();
        idle();
        read_all("R1");
        check_views("R7");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule